// File: doc/BRIEF.md
# Received Audio Word Length Formatter

This block takes the audio payload of each received S/PDIF subframe and prepares it for two consumers. The first is a retransmit path, which expects a 24-bit sample. The second is a serial audio interface, which runs at a word width set by software. A 24-bit audio field sits at a fixed position inside the 32-bit subframe slot, and the block always extracts it. The sample may actually hold fewer valid bits, as the channel status word-length information signals. Unless a keep-all control is set, the bits below that signalled length are cleared.

For the audio interface, the block applies a second, unconditional fit. If the interface word is narrower than the sample, the low bits are dropped. If it is wider, the sample stays MSB-aligned and the spare low bits read as zero. Both outputs are presented MSB-aligned on 24-bit ports. They are registered and marked by a single-cycle valid strobe one clock after the input strobe. Decoding the channel status stream and serialising the samples are done elsewhere.

Top module: `rx_wordlen_fmt`

## Requirements
- R1: The audio field is `in_slot[27:4]`. Slot bits 31:28 and 3:0 never reach either output.
- R2: With `cs_max_long`=1, `cs_len_code` selects the signalled length: 3'b001→20, 3'b110→21, 3'b010→22, 3'b100→23, 3'b101→24. Every other code (000, 011, 111) is taken as 24.
- R3: With `cs_max_long`=0, the signalled length is 20 bits whatever `cs_len_code` holds.
- R4: With `wl_keep_all`=1, `tx_sample` equals the whole 24-bit audio field, whatever the signalled length.
- R5: With `wl_keep_all`=0, `tx_sample` keeps the top L bits of the field, where L is the signalled length, and clears the lower 24-L bits.
- R6: `ifc_width_sel` picks the interface width W: 2'b00→16, 2'b01→20, 2'b10→24, 2'b11→24. `ifc_sample` keeps the top min(L',W) bits of the field and clears all others. L' is 24 when `wl_keep_all`=1 and L otherwise, so the fit to W applies even when keep-all is set.
- R7: When W exceeds L', the bits of `ifc_sample` below the top L' are zero. For example, a 21-bit sample on a 24-bit interface has three zero LSBs.
- R8: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. Without `in_valid`, both sample outputs hold their values.
- R9: While `rst_n` is low, `out_valid`, `tx_sample` and `ifc_sample` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A subframe slot is present this cycle |
| in_slot | input | 32 | Received subframe slot |
| cs_max_long | input | 1 | Channel status maximum-length flag (1: 24-bit class) |
| cs_len_code | input | 3 | Channel status word-length code |
| wl_keep_all | input | 1 | Pass all 24 bits and skip the signalled-length cut |
| ifc_width_sel | input | 2 | Audio interface word width select |
| out_valid | output | 1 | Formatted samples updated this cycle |
| tx_sample | output | 24 | Sample for the retransmit path, MSB-aligned |
| ifc_sample | output | 24 | Sample for the audio interface, MSB-aligned |

## Verification
The assertions assume that the length code, the keep-all flag and the width select are sampled only in cycles where `in_valid` is high. They also assume these controls follow the encodings of R2, R3 and R6, and no further meaning is given to reserved values. The stimulus changes every input only on the falling clock edge. It drives each control combination for a single strobed cycle and then drops the strobe, so each check sees one sample whose configuration is known. The sweep covers every setting of the maximum-length flag, length code, keep-all flag and width select. For each setting it applies slot patterns that include all ones, bits set only outside the audio field, and pseudo-random words with their complements.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

   // Audio interface word width selection
   typedef enum logic [1:0] {
      IFC_W_NARROW = 2'b00,
      IFC_W_MID    = 2'b01,
      IFC_W_WIDE   = 2'b10,
      IFC_W_RSVD   = 2'b11
   } ifc_width_e;

   // Word-length codes valid in the long (24-bit class) range
   localparam logic [2:0] WLC_MINUS4 = 3'b001;
   localparam logic [2:0] WLC_MINUS3 = 3'b110;
   localparam logic [2:0] WLC_MINUS2 = 3'b010;
   localparam logic [2:0] WLC_MINUS1 = 3'b100;
   localparam logic [2:0] WLC_FULL   = 3'b101;

   localparam int WLC_W = 3;

endpackage

// File: rtl/rwf_len_decode.sv
module rwf_len_decode
   import rwf_pkg::*;
#(
   parameter int FIELD_W  = 24,
   parameter int BASE_LEN = 20,
   parameter int LEN_W    = $clog2(FIELD_W + 1)
) (
   input  logic             max_long,
   input  logic [WLC_W-1:0] code,
   output logic [LEN_W-1:0] len
);

   localparam int SPAN = FIELD_W - BASE_LEN;

   if (SPAN != 4) begin : g_bad_span
      $error("rwf_len_decode: FIELD_W - BASE_LEN must be 4");
   end

   always_comb begin
      if (!max_long) begin
         len = LEN_W'(BASE_LEN);
      end else begin
         unique case (code)
            WLC_MINUS4: len = LEN_W'(FIELD_W - 4);
            WLC_MINUS3: len = LEN_W'(FIELD_W - 3);
            WLC_MINUS2: len = LEN_W'(FIELD_W - 2);
            WLC_MINUS1: len = LEN_W'(FIELD_W - 1);
            WLC_FULL:   len = LEN_W'(FIELD_W);
            default:    len = LEN_W'(FIELD_W);
         endcase
      end
   end

endmodule

// File: rtl/rwf_ifc_width.sv
module rwf_ifc_width
   import rwf_pkg::*;
#(
   parameter int FIELD_W    = 24,
   parameter int IFC_NARROW = 16,
   parameter int IFC_MID    = 20,
   parameter int LEN_W      = $clog2(FIELD_W + 1)
) (
   input  logic [1:0]       sel,
   output logic [LEN_W-1:0] width
);

   if (!(IFC_NARROW < IFC_MID && IFC_MID <= FIELD_W)) begin : g_bad_widths
      $error("rwf_ifc_width: widths must satisfy NARROW < MID <= FIELD_W");
   end

   always_comb begin
      unique case (ifc_width_e'(sel))
         IFC_W_NARROW: width = LEN_W'(IFC_NARROW);
         IFC_W_MID:    width = LEN_W'(IFC_MID);
         IFC_W_WIDE:   width = LEN_W'(FIELD_W);
         default:      width = LEN_W'(FIELD_W);
      endcase
   end

endmodule

// File: rtl/rwf_msb_keep.sv
module rwf_msb_keep #(
   parameter int FIELD_W = 24,
   parameter int LEN_W   = $clog2(FIELD_W + 1)
) (
   input  logic [LEN_W-1:0]   len,
   output logic [FIELD_W-1:0] mask
);

   if (LEN_W < $clog2(FIELD_W + 1)) begin : g_bad_len_w
      $error("rwf_msb_keep: LEN_W too small for FIELD_W");
   end

   // Bit i survives when it lies within the top len bits.
   for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
      assign mask[i] = (int'(len) + i) >= FIELD_W;
   end

endmodule

// File: rtl/rx_wordlen_fmt.sv
module rx_wordlen_fmt
   import rwf_pkg::*;
#(
   parameter int SLOT_W     = 32,
   parameter int FIELD_W    = 24,
   parameter int FIELD_LSB  = 4,
   parameter int BASE_LEN   = 20,
   parameter int IFC_NARROW = 16,
   parameter int IFC_MID    = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [SLOT_W-1:0]  in_slot,
   input  logic               cs_max_long,
   input  logic [2:0]         cs_len_code,
   input  logic               wl_keep_all,
   input  logic [1:0]         ifc_width_sel,
   output logic               out_valid,
   output logic [FIELD_W-1:0] tx_sample,
   output logic [FIELD_W-1:0] ifc_sample
);

   localparam int LEN_W = $clog2(FIELD_W + 1);

   if (FIELD_LSB + FIELD_W > SLOT_W) begin : g_bad_field
      $error("rx_wordlen_fmt: audio field exceeds slot");
   end

   logic [FIELD_W-1:0] field;
   logic [LEN_W-1:0]   sig_len;
   logic [LEN_W-1:0]   eff_len;
   logic [LEN_W-1:0]   ifc_w;
   logic [LEN_W-1:0]   ifc_len;
   logic [FIELD_W-1:0] tx_mask;
   logic [FIELD_W-1:0] ifc_mask;

   assign field = in_slot[FIELD_LSB +: FIELD_W];

   rwf_len_decode #(
      .FIELD_W  (FIELD_W),
      .BASE_LEN (BASE_LEN),
      .LEN_W    (LEN_W)
   ) u_len_decode (
      .max_long (cs_max_long),
      .code     (cs_len_code),
      .len      (sig_len)
   );

   rwf_ifc_width #(
      .FIELD_W    (FIELD_W),
      .IFC_NARROW (IFC_NARROW),
      .IFC_MID    (IFC_MID),
      .LEN_W      (LEN_W)
   ) u_ifc_width (
      .sel   (ifc_width_sel),
      .width (ifc_w)
   );

   // Maskable cut to signalled length, then unmaskable fit to interface
   assign eff_len = wl_keep_all ? LEN_W'(FIELD_W) : sig_len;
   assign ifc_len = (ifc_w < eff_len) ? ifc_w : eff_len;

   rwf_msb_keep #(
      .FIELD_W (FIELD_W),
      .LEN_W   (LEN_W)
   ) u_tx_keep (
      .len  (eff_len),
      .mask (tx_mask)
   );

   rwf_msb_keep #(
      .FIELD_W (FIELD_W),
      .LEN_W   (LEN_W)
   ) u_ifc_keep (
      .len  (ifc_len),
      .mask (ifc_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         tx_sample  <= '0;
         ifc_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            tx_sample  <= field & tx_mask;
            ifc_sample <= field & ifc_mask;
         end
      end
   end

endmodule

// File: rtl/rx_wordlen_fmt_chk.sv
module rx_wordlen_fmt_chk #(
   parameter int SLOT_W     = 32,
   parameter int FIELD_W    = 24,
   parameter int FIELD_LSB  = 4,
   parameter int BASE_LEN   = 20,
   parameter int IFC_NARROW = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [SLOT_W-1:0]  in_slot,
   input logic               cs_max_long,
   input logic               wl_keep_all,
   input logic [1:0]         ifc_width_sel,
   input logic               out_valid,
   input logic [FIELD_W-1:0] tx_sample,
   input logic [FIELD_W-1:0] ifc_sample
);

   AST_OUT_WITHIN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((tx_sample & ~$past(in_slot[FIELD_LSB +: FIELD_W])) == '0)); // R1

   AST_SHORT_CLASS_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wl_keep_all && !cs_max_long)
      |=> (tx_sample[FIELD_W-BASE_LEN-1:0] == '0)); // R3

   AST_KEEP_ALL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wl_keep_all) |=> (tx_sample == $past(in_slot[FIELD_LSB +: FIELD_W]))); // R4

   AST_IFC_SUBSET_TX: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((ifc_sample & ~tx_sample) == '0)); // R6

   AST_NARROW_IFC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ifc_width_sel == 2'b00)
      |=> (ifc_sample[FIELD_W-IFC_NARROW-1:0] == '0)); // R6

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(tx_sample) && $stable(ifc_sample))); // R8

endmodule

bind rx_wordlen_fmt rx_wordlen_fmt_chk #(
   .SLOT_W     (SLOT_W),
   .FIELD_W    (FIELD_W),
   .FIELD_LSB  (FIELD_LSB),
   .BASE_LEN   (BASE_LEN),
   .IFC_NARROW (IFC_NARROW)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_slot       (in_slot),
   .cs_max_long   (cs_max_long),
   .wl_keep_all   (wl_keep_all),
   .ifc_width_sel (ifc_width_sel),
   .out_valid     (out_valid),
   .tx_sample     (tx_sample),
   .ifc_sample    (ifc_sample)
);

// File: tb/rx_wordlen_fmt_bench.sv
`timescale 1ns/1ps
module rx_wordlen_fmt_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_slot = '0;
   logic        cs_max_long = 1'b0;
   logic [2:0]  cs_len_code = '0;
   logic        wl_keep_all = 1'b0;
   logic [1:0]  ifc_width_sel = '0;
   logic        out_valid;
   logic [23:0] tx_sample;
   logic [23:0] ifc_sample;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rx_wordlen_fmt u_rx_wordlen_fmt (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_slot       (in_slot),
      .cs_max_long   (cs_max_long),
      .cs_len_code   (cs_len_code),
      .wl_keep_all   (wl_keep_all),
      .ifc_width_sel (ifc_width_sel),
      .out_valid     (out_valid),
      .tx_sample     (tx_sample),
      .ifc_sample    (ifc_sample)
   );

   function automatic int exp_len(input logic ml, input logic [2:0] c, input logic keep);
      if (keep) return 24;
      if (!ml)  return 20;
      case (c)
         3'b001:  return 20;
         3'b110:  return 21;
         3'b010:  return 22;
         3'b100:  return 23;
         default: return 24;
      endcase
   endfunction

   function automatic int exp_w(input logic [1:0] s);
      case (s)
         2'b00:   return 16;
         2'b01:   return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [23:0] top_bits(input int n);
      logic [47:0] wide;
      wide = 48'hFF_FFFF << (24 - n);
      return wide[23:0];
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [23:0] act, input logic [23:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] slot, input logic ml, input logic [2:0] c,
                        input logic keep, input logic [1:0] s, input bit outside_only);
      int          l;
      int          w;
      int          lw;
      logic [23:0] fld;
      @(negedge clk);
      in_valid      = 1'b1;
      in_slot       = slot;
      cs_max_long   = ml;
      cs_len_code   = c;
      wl_keep_all   = keep;
      ifc_width_sel = s;
      @(negedge clk);
      in_valid = 1'b0;
      in_slot  = ~slot;
      l   = exp_len(ml, c, keep);
      w   = exp_w(s);
      lw  = (w < l) ? w : l;
      fld = slot[27:4];
      chk("R8", "out_valid after strobe", {23'd0, out_valid}, 24'd1);
      if (outside_only) begin
         chk("R1", "tx from outside bits", tx_sample, 24'd0);
         chk("R1", "ifc from outside bits", ifc_sample, 24'd0);
      end else begin
         if (keep)
            chk("R4", "tx keep-all", tx_sample, fld);
         else if (!ml)
            chk("R3/R5", "tx short class", tx_sample, fld & top_bits(l));
         else
            chk("R2/R5", "tx long class", tx_sample, fld & top_bits(l));
         if (w > l)
            chk("R7", "ifc zero fill", ifc_sample, fld & top_bits(lw));
         else
            chk("R6", "ifc width fit", ifc_sample, fld & top_bits(lw));
      end
   endtask

   task automatic hold_check;
      logic [23:0] t0;
      logic [23:0] i0;
      t0 = tx_sample;
      i0 = ifc_sample;
      @(negedge clk);
      chk("R8", "out_valid idle", {23'd0, out_valid}, 24'd0);
      chk("R8", "tx hold", tx_sample, t0);
      chk("R8", "ifc hold", ifc_sample, i0);
   endtask

   initial begin
      logic [31:0] lcg;
      lcg = 32'h1357_9BDF;
      repeat (3) @(negedge clk);
      chk("R9", "reset out_valid", {23'd0, out_valid}, 24'd0);
      chk("R9", "reset tx", tx_sample, 24'd0);
      chk("R9", "reset ifc", ifc_sample, 24'd0);
      rst_n = 1'b1;
      for (int ml = 0; ml < 2; ml++) begin
         for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 2; k++) begin
               for (int s = 0; s < 4; s++) begin
                  lcg = lcg * 32'd1664525 + 32'd1013904223;
                  apply(32'hFFFF_FFFF, ml[0], c[2:0], k[0], s[1:0], 1'b0);
                  apply(32'hF000_000F, ml[0], c[2:0], k[0], s[1:0], 1'b1);
                  apply(lcg, ml[0], c[2:0], k[0], s[1:0], 1'b0);
                  apply(~lcg, ml[0], c[2:0], k[0], s[1:0], 1'b0);
                  hold_check();
               end
            end
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule